// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Program ROM Decoder

This block joins a small controller whose low address byte and data byte share one 8-bit bus to two external program ROM sites. While the address strobe is high it captures the shared bus as the low address byte. It then joins that byte with the eight dedicated upper address lines to form a 16-bit address.

The two top address bits pick one of the two ROM sites. Each site has an active-low chip select, and both selects are gated by the enable clock. The ROMs therefore stay off the shared bus while the low byte is being captured. During the enable-high phase of a read, the block drives the selected ROM's byte back onto the shared bus. In every other case its bus driver stays released.

Each site is sized by a parameter to 2, 4 or 8 KB. A smaller site receives only its low 11, 12 or 13 address bits. It therefore repeats through its 16 KB window.

Top module: `muxbus_rom_decoder`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the captured low byte is cleared to 0x00, whatever the strobe and bus inputs are.
- R2: On a rising `clk` edge where `as_i` is 1, the captured low byte takes the value of `bus_i`. It is visible on `addr_o[7:0]` after that edge.
- R3: On a rising `clk` edge where `as_i` is 0, the captured low byte keeps its value, even if `bus_i` changes.
- R4: `addr_o` is `{hi_addr_i, captured low byte}`, with `hi_addr_i` in bits 15:8.
- R5: `rom_a_cs_n_o` is 0 exactly when `e_i` is 1, address bit 15 is 1 and address bit 14 is 1.
- R6: `rom_b_cs_n_o` is 0 exactly when `e_i` is 1, address bit 15 is 1 and address bit 14 is 0.
- R7: When `e_i` is 0 or address bit 15 is 0, both chip selects are 1. The two selects are never 0 at the same time.
- R8: `bus_oe_o` is 1 exactly when a chip select is 0 and `rw_i` is 1 (read). While it is 1, `bus_o` equals the data input of the selected site.
- R9: A write (`rw_i` = 0) never raises `bus_oe_o`, even when the address selects a ROM.
- R10: Each site's address output carries the low N bits of `addr_o`, where N is 11, 12 or 13 for a 2, 4 or 8 KB site. Addresses that differ only above bit N-1 therefore give the same site address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_i | input | 1 | Address strobe, high while the shared bus carries the low address |
| e_i | input | 1 | Enable clock, high during the data phase |
| rw_i | input | 1 | 1 = read, 0 = write |
| hi_addr_i | input | 8 | Dedicated upper address lines 15:8 |
| bus_i | input | 8 | Shared address/data bus as seen by the block |
| bus_o | output | 8 | Byte driven onto the shared bus |
| bus_oe_o | output | 1 | Drive enable for `bus_o` |
| addr_o | output | 16 | Full demultiplexed address |
| rom_a_cs_n_o | output | 1 | Active-low select of site A (bit 14 = 1) |
| rom_b_cs_n_o | output | 1 | Active-low select of site B (bit 14 = 0) |
| rom_a_addr_o | output | A_AW | Address into site A |
| rom_b_addr_o | output | B_AW | Address into site B |
| rom_a_data_i | input | 8 | Data returned by site A |
| rom_b_data_i | input | 8 | Data returned by site B |

## Verification
The bench builds the block with site A at 2 KB and site B at 4 KB. This makes the two sites truncate the address at different bit positions, so the repeat of both sites inside their windows can be seen. All 256 low byte values are swept through capture and hold. All 256 upper address values are then swept against every combination of enable and read/write. This covers every decode region and both truncation widths, and the expected values are worked out by bit arithmetic.

// File: rtl/muxrom_pkg.sv
// Package: shared types and size helpers for the multiplexed-bus ROM decoder.
// Assumes site sizes are given in kilobytes as 2, 4 or 8.
package muxrom_pkg;
    typedef logic [7:0]  byte_t;
    typedef logic [15:0] addr_t;

    // Address width used by a ROM site of the given size in KB.
    function automatic int kb_to_aw(input int kb);
        if (kb >= 8)      return 13;
        else if (kb >= 4) return 12;
        else              return 11;
    endfunction
endpackage

// File: rtl/lo_addr_capture.sv
// Module: lo_addr_capture
// Captures the low address byte from the shared bus on each clock edge where
// the address strobe is high, and holds it otherwise.
// Assumes the strobe is already synchronous to clk.
module lo_addr_capture
    import muxrom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  as_i,
    input  byte_t bus_i,
    output byte_t lo_o
);
    byte_t lo_q;

    // Follow the bus while the strobe is high; hold once it has fallen.
    always_ff @(posedge clk) begin
        if (!rst_n)    lo_q <= '0;
        else if (as_i) lo_q <= bus_i;
    end

    assign lo_o = lo_q;

    // R2
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_i |=> (lo_o == $past(bus_i)));
    // R3
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |=> $stable(lo_o));
endmodule

// File: rtl/rom_site_decode.sv
// Module: rom_site_decode
// Turns address bits 15:14 into two active-low ROM selects, gated by the
// enable clock so that neither ROM is selected during the address phase.
// Assumes the address bits are stable while enable is high.
module rom_site_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_i,
    input  logic [1:0] top_bits_i,
    output logic       cs_a_n_o,
    output logic       cs_b_n_o
);
    logic in_rom_space;

    // Decode the window and pick a site while enable is high.
    always_comb begin
        in_rom_space = e_i & top_bits_i[1];
        cs_a_n_o     = ~(in_rom_space &  top_bits_i[0]);
        cs_b_n_o     = ~(in_rom_space & ~top_bits_i[0]);
    end

    // R7
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~cs_a_n_o, ~cs_b_n_o}));
    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_i || !top_bits_i[1]) |-> (cs_a_n_o && cs_b_n_o));
endmodule

// File: rtl/bus_return_steer.sv
// Module: bus_return_steer
// Chooses the byte of the selected site and enables the bus driver only for
// a read while a select is active.
// Assumes at most one select is active.
module bus_return_steer
    import muxrom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rw_i,
    input  logic  cs_a_n_i,
    input  logic  cs_b_n_i,
    input  byte_t data_a_i,
    input  byte_t data_b_i,
    output byte_t bus_o,
    output logic  oe_o
);
    // Drive the selected ROM byte; park the output at zero when idle.
    always_comb begin
        oe_o  = rw_i & (~cs_a_n_i | ~cs_b_n_i);
        bus_o = '0;
        if (!cs_a_n_i)      bus_o = data_a_i;
        else if (!cs_b_n_i) bus_o = data_b_i;
    end

    // R9
    no_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_i |-> !oe_o);
    // R8
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> (!cs_a_n_i || !cs_b_n_i));
endmodule

// File: rtl/muxbus_rom_decoder.sv
// Module: muxbus_rom_decoder (top)
// Demultiplexes the low address from a shared address/data bus, decodes two
// program ROM sites, and returns ROM data onto the bus on reads.
// Assumes bus control inputs are synchronous to clk.
module muxbus_rom_decoder
    import muxrom_pkg::*;
#(
    parameter  int ROM_A_KB = 8,
    parameter  int ROM_B_KB = 8,
    localparam int A_AW     = kb_to_aw(ROM_A_KB),
    localparam int B_AW     = kb_to_aw(ROM_B_KB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_i,
    input  logic            e_i,
    input  logic            rw_i,
    input  logic [7:0]      hi_addr_i,
    input  logic [7:0]      bus_i,
    output logic [7:0]      bus_o,
    output logic            bus_oe_o,
    output logic [15:0]     addr_o,
    output logic            rom_a_cs_n_o,
    output logic            rom_b_cs_n_o,
    output logic [A_AW-1:0] rom_a_addr_o,
    output logic [B_AW-1:0] rom_b_addr_o,
    input  logic [7:0]      rom_a_data_i,
    input  logic [7:0]      rom_b_data_i
);
    byte_t lo_byte;
    addr_t full_addr;

    lo_addr_capture u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .as_i  (as_i),
        .bus_i (bus_i),
        .lo_o  (lo_byte)
    );

    // Join the dedicated upper lines with the captured low byte.
    assign full_addr = {hi_addr_i, lo_byte};
    assign addr_o    = full_addr;

    rom_site_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .e_i        (e_i),
        .top_bits_i (full_addr[15:14]),
        .cs_a_n_o   (rom_a_cs_n_o),
        .cs_b_n_o   (rom_b_cs_n_o)
    );

    // Each site only sees its own low address bits, so small sites repeat.
    assign rom_a_addr_o = full_addr[A_AW-1:0];
    assign rom_b_addr_o = full_addr[B_AW-1:0];

    bus_return_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rw_i     (rw_i),
        .cs_a_n_i (rom_a_cs_n_o),
        .cs_b_n_i (rom_b_cs_n_o),
        .data_a_i (rom_a_data_i),
        .data_b_i (rom_b_data_i),
        .bus_o    (bus_o),
        .oe_o     (bus_oe_o)
    );

    // R8
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && !rom_a_cs_n_o) |-> (bus_o == rom_a_data_i));
endmodule

// File: tb/muxbus_rom_decoder_tb.sv
module muxbus_rom_decoder_tb;
    localparam int AKB = 2;
    localparam int BKB = 4;
    localparam int AAW = 11;
    localparam int BAW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_i = 1'b0, e_i = 1'b0, rw_i = 1'b1;
    logic [7:0] hi_addr = '0, bus_in = '0, bus_out, da = '0, db = '0;
    logic oe, cs_a_n, cs_b_n;
    logic [15:0] addr;
    logic [AAW-1:0] a_addr;
    logic [BAW-1:0] b_addr;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    muxbus_rom_decoder #(.ROM_A_KB(AKB), .ROM_B_KB(BKB)) u_dut (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .e_i(e_i), .rw_i(rw_i),
        .hi_addr_i(hi_addr), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe),
        .addr_o(addr), .rom_a_cs_n_o(cs_a_n), .rom_b_cs_n_o(cs_b_n),
        .rom_a_addr_o(a_addr), .rom_b_addr_o(b_addr),
        .rom_a_data_i(da), .rom_b_data_i(db)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [7:0] lo);
        @(negedge clk);
        as_i = 1'b1; bus_in = lo;
        @(negedge clk);
        as_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset wins over an active strobe
        as_i = 1'b1; bus_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", {24'd0, addr[7:0]}, 32'h00);
        as_i = 1'b0;
        rst_n = 1'b1;

        // R2, R3: sweep every low byte through capture and hold
        for (int lo = 0; lo < 256; lo++) begin
            capture(lo[7:0]);
            check("R2", {24'd0, addr[7:0]}, lo);
            bus_in = ~lo[7:0];
            @(negedge clk);
            check("R3", {24'd0, addr[7:0]}, lo);
        end

        // R4-R10: every upper byte against every enable and direction
        for (int hi = 0; hi < 256; hi++) begin
            logic [7:0] lo;
            logic [15:0] full;
            lo = 8'(hi * 37 + 11);
            hi_addr = hi[7:0];
            da = 8'(hi ^ 8'h5A);
            db = 8'(hi + 8'h33);
            capture(lo);
            #1;
            full = {hi[7:0], lo};
            check("R4", {16'd0, addr}, {16'd0, full});
            check("R10 site A", {21'd0, a_addr}, {16'd0, full & 16'h07FF});
            check("R10 site B", {20'd0, b_addr}, {16'd0, full & 16'h0FFF});
            for (int c = 0; c < 4; c++) begin
                logic ea, sa, sb, eoe;
                e_i = c[0]; rw_i = c[1];
                #1;
                ea  = c[0] & full[15];
                sa  = ea & full[14];
                sb  = ea & ~full[14];
                eoe = (sa | sb) & c[1];
                check("R5", {31'd0, cs_a_n}, {31'd0, ~sa});
                check("R6", {31'd0, cs_b_n}, {31'd0, ~sb});
                if (!ea) check("R7", {30'd0, cs_a_n, cs_b_n}, 32'd3);
                if (!c[1]) check("R9", {31'd0, oe}, 32'd0);
                else       check("R8 oe", {31'd0, oe}, {31'd0, eoe});
                if (eoe) check("R8 data", {24'd0, bus_out}, {24'd0, sa ? da : db});
            end
            e_i = 1'b0; rw_i = 1'b1;
        end

        // R10: aliasing, two addresses 2K apart hit the same site A location
        hi_addr = 8'hC1; capture(8'h23); #1;
        begin
            logic [AAW-1:0] first;
            first = a_addr;
            hi_addr = 8'hC9; #1;
            check("R10 alias", {21'd0, a_addr}, {21'd0, first});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule